// File: doc/BRIEF.md
# Regulator Power-Up Sequencer with Soft-Start

This block controls the startup of a switching regulator controller. Digitized samples of four nodes arrive every clock: the input rail, the internal bias rail, the enable pin and the feedback node. Each rail and the enable pass through a threshold comparator with hysteresis. A state machine then steps through four states: deep shutdown, standby, soft-start ramp and regulate. During the ramp it produces a linear digital reference that climbs from zero to a target code.

The switching-enable output stays low through the ramp until the reference rises above the feedback sample. This way an output that is already charged is not pulled down. A restart request discards the ramp and runs the soft-start again. When the enable sample falls below a deep threshold, the block raises a flag that lets the bias circuitry power down. It also clears every piece of sequencing state.

All thresholds, the target, the clock rate and the ramp time are parameters. Thresholds and the target are in ADC codes, and the ramp time is in nanoseconds. The per-clock ramp increment is computed at elaboration as a fixed-point fraction.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: A rail qualifies only when its sample is strictly greater than its on threshold (default 2900). The ramp starts only when the input rail, the bias rail and the enable are all qualified. The reference reads 1 step on the third rising edge after the last of them crosses.
- R2: A qualified rail stays qualified while its sample is at or above its off threshold (default 2600). It drops on the first edge that samples a code below that threshold.
- R3: The enable qualifies above its on threshold (default 1170, where 1170 itself does not qualify). It stays qualified down to its off threshold (default 1070). It drops on the first edge that samples a code below 1070.
- R4: An enable sample below the deep threshold (default 800) sets `deep_sd_o` on the next edge, with `sw_en_o` low and `ref_o` zero. Both rail qualifications are cleared, so the rails must cross their on thresholds again after the block leaves deep shutdown.
- R5: The reference starts at 0 and rises by a constant fixed-point step each clock. It reaches the target after CLK_KHZ*RAMP_NS/1e6 clocks, never exceeds the target, and then holds exactly at the target.
- R6: `sw_en_o` stays low during the ramp. It rises on the edge after the registered reference is first greater than the feedback sample, so with a unit step it rises with `ref_o` equal to feedback+2. It then stays high.
- R7: If the feedback sample is at or above the target, `sw_en_o` never rises during that startup.
- R8: A restart request sampled while ramping or regulating sets `ref_o` to 0 and `sw_en_o` low on that edge. The ramp then climbs again from the next edge.
- R9: If a rail or the enable loses qualification, `sw_en_o` falls on the same edge that samples the offending code. `ref_o` returns to 0 one edge later, in standby.
- R10: During and right after reset the block is in deep shutdown: `deep_sd_o` is high, `sw_en_o` is low and `ref_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vin_code_i | input | CODE_W | Input rail sample |
| vbias_code_i | input | CODE_W | Internal bias rail sample |
| en_code_i | input | CODE_W | Enable pin sample |
| fb_code_i | input | CODE_W | Feedback node sample |
| restart_i | input | 1 | Request to discharge and re-run the ramp |
| ref_o | output | CODE_W | Soft-start reference code |
| sw_en_o | output | 1 | Switching enable |
| deep_sd_o | output | 1 | Deep shutdown flag (bias off) |

## Verification
The bench keeps every threshold and the target of 1000 at their defaults. It only shortens the ramp time to 8000 ns at the 125 MHz clock. This gives a 1000-clock ramp whose step is exactly one code per clock, so every reference value, the switching-enable edge at feedback+2 and the saturation point can be predicted to the cycle. The short ramp also lets all scenarios fit in a few thousand cycles. Those scenarios cover codes exactly on each threshold, the hysteresis bands, deep-shutdown clearing and a feedback sample equal to the target.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    ST_DEEP  = 2'd0,
    ST_STBY  = 2'd1,
    ST_RAMP  = 2'd2,
    ST_REG   = 2'd3
  } seq_state_e;

  localparam int unsigned NCH    = 3;
  localparam int unsigned CH_VIN = 0;
  localparam int unsigned CH_VB  = 1;
  localparam int unsigned CH_EN  = 2;
endpackage

// File: rtl/pwr_seq_hyst.sv
module pwr_seq_hyst #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned ON_TH  = 2900,
  parameter int unsigned OFF_TH = 2600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] x_i,
  output logic              ok_o
);
  localparam logic [CODE_W-1:0] ON_C  = CODE_W'(ON_TH);
  localparam logic [CODE_W-1:0] OFF_C = CODE_W'(OFF_TH);

  logic ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ok_q <= 1'b0;
    else if (clr_i)  ok_q <= 1'b0;
    else if (ok_q)   ok_q <= (x_i >= OFF_C);
    else             ok_q <= (x_i > ON_C);
  end

  assign ok_o = ok_q;

  AST_QUAL_ABOVE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_o) |-> ($past(x_i) > ON_C)); // R1
  AST_DROP_BELOW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ok_o) |-> (($past(x_i) < OFF_C) || $past(clr_i))); // R2
endmodule

// File: rtl/pwr_seq_ramp.sv
module pwr_seq_ramp #(
  parameter int unsigned CODE_W  = 12,
  parameter int unsigned FRAC_W  = 16,
  parameter int unsigned TARGET  = 1000,
  parameter int unsigned CLK_KHZ = 125000,
  parameter int unsigned RAMP_NS = 1280000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  output logic [CODE_W-1:0] ref_o
);
  localparam int unsigned ACC_W    = CODE_W + FRAC_W + 1;
  localparam longint      RAMP_CYC = (longint'(CLK_KHZ) * longint'(RAMP_NS)) / 64'd1000000;
  localparam longint      CYC_SAFE = (RAMP_CYC < 1) ? 64'd1 : RAMP_CYC;
  localparam longint      STEP_RAW = (longint'(TARGET) << FRAC_W) / CYC_SAFE;
  localparam longint      STEP_L   = (STEP_RAW < 1) ? 64'd1 : STEP_RAW;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(STEP_L);
  localparam logic [ACC_W-1:0] SAT  = ACC_W'(longint'(TARGET) << FRAC_W);
  localparam logic [CODE_W-1:0] TGT_C = CODE_W'(TARGET);

  logic [ACC_W-1:0] acc_q, acc_sum;

  assign acc_sum = acc_q + STEP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (run_i)  acc_q <= (acc_sum >= SAT) ? SAT : acc_sum;
  end

  assign ref_o = acc_q[FRAC_W +: CODE_W];

  AST_REF_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o <= TGT_C); // R5
  AST_REF_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i) |=> (ref_o >= $past(ref_o))); // R5
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned TARGET = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              deep_i,
  input  logic              ok_i,
  input  logic              restart_i,
  input  logic [CODE_W-1:0] ref_i,
  input  logic [CODE_W-1:0] fb_i,
  output logic              ramp_clr_o,
  output logic              ramp_run_o,
  output logic              sw_en_o,
  output logic              deep_o,
  output seq_state_e        state_o
);
  localparam logic [CODE_W-1:0] TGT_C = CODE_W'(TARGET);

  seq_state_e state_q, state_d;
  logic       active_q, restart_take;

  assign active_q     = (state_q == ST_RAMP) || (state_q == ST_REG);
  assign restart_take = active_q && restart_i && ok_i && !deep_i;

  always_comb begin
    state_d = state_q;
    if (deep_i) state_d = ST_DEEP;
    else begin
      unique case (state_q)
        ST_DEEP: state_d = ST_STBY;
        ST_STBY: if (ok_i) state_d = ST_RAMP;
        ST_RAMP: begin
          if (!ok_i)              state_d = ST_STBY;
          else if (restart_i)     state_d = ST_RAMP;
          else if (ref_i > fb_i)  state_d = ST_REG;
        end
        ST_REG: begin
          if (!ok_i)              state_d = ST_STBY;
          else if (restart_i)     state_d = ST_RAMP;
        end
        default: state_d = ST_DEEP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_DEEP;
    else         state_q <= state_d;
  end

  // ramp starts from zero on the first active cycle
  assign ramp_clr_o = !active_q || (state_d == ST_DEEP) || (state_d == ST_STBY) || restart_take;
  assign ramp_run_o = !ramp_clr_o;
  assign sw_en_o    = (state_q == ST_REG) && ok_i;
  assign deep_o     = (state_q == ST_DEEP);
  assign state_o    = state_q;

  AST_SW_AFTER_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_REG) |-> ($past(ref_i) > $past(fb_i))); // R6
  AST_FB_ABOVE_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_RAMP) && (fb_i >= TGT_C)) |=> (state_q != ST_REG)); // R7
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned FRAC_W   = 16,
  parameter int unsigned VIN_ON   = 2900,
  parameter int unsigned VIN_OFF  = 2600,
  parameter int unsigned VB_ON    = 2900,
  parameter int unsigned VB_OFF   = 2600,
  parameter int unsigned EN_ON    = 1170,
  parameter int unsigned EN_OFF   = 1070,
  parameter int unsigned EN_DEEP  = 800,
  parameter int unsigned TARGET   = 1000,
  parameter int unsigned CLK_KHZ  = 125000,
  parameter int unsigned RAMP_NS  = 1280000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] vin_code_i,
  input  logic [CODE_W-1:0] vbias_code_i,
  input  logic [CODE_W-1:0] en_code_i,
  input  logic [CODE_W-1:0] fb_code_i,
  input  logic              restart_i,
  output logic [CODE_W-1:0] ref_o,
  output logic              sw_en_o,
  output logic              deep_sd_o
);
  localparam int unsigned ON_A  [NCH] = '{VIN_ON,  VB_ON,  EN_ON};
  localparam int unsigned OFF_A [NCH] = '{VIN_OFF, VB_OFF, EN_OFF};
  localparam logic [CODE_W-1:0] DEEP_C = CODE_W'(EN_DEEP);

  logic [CODE_W-1:0] x_a [NCH];
  logic [NCH-1:0]    ok_a;
  logic              deep_now, ok_all, ramp_clr, ramp_run;
  seq_state_e        state;

  assign x_a[CH_VIN] = vin_code_i;
  assign x_a[CH_VB]  = vbias_code_i;
  assign x_a[CH_EN]  = en_code_i;
  assign deep_now    = (en_code_i < DEEP_C);
  assign ok_all      = &ok_a;

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    pwr_seq_hyst #(
      .CODE_W (CODE_W),
      .ON_TH  (ON_A[g]),
      .OFF_TH (OFF_A[g])
    ) u_cmp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (deep_now),
      .x_i    (x_a[g]),
      .ok_o   (ok_a[g])
    );
  end

  pwr_seq_fsm #(
    .CODE_W (CODE_W),
    .TARGET (TARGET)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .deep_i     (deep_now),
    .ok_i       (ok_all),
    .restart_i  (restart_i),
    .ref_i      (ref_o),
    .fb_i       (fb_code_i),
    .ramp_clr_o (ramp_clr),
    .ramp_run_o (ramp_run),
    .sw_en_o    (sw_en_o),
    .deep_o     (deep_sd_o),
    .state_o    (state)
  );

  pwr_seq_ramp #(
    .CODE_W  (CODE_W),
    .FRAC_W  (FRAC_W),
    .TARGET  (TARGET),
    .CLK_KHZ (CLK_KHZ),
    .RAMP_NS (RAMP_NS)
  ) u_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ramp_clr),
    .run_i  (ramp_run),
    .ref_o  (ref_o)
  );

  AST_DEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deep_sd_o |-> (!sw_en_o && (ref_o == '0))); // R4
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && ((state == ST_RAMP) || (state == ST_REG))) |=> ((ref_o == '0) && !sw_en_o)); // R8
  AST_LOSS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ok_all) |=> (ref_o == '0)); // R9
  AST_RESET_DEEP: assert property (@(posedge clk_i)
    !rst_ni |-> (deep_sd_o && !sw_en_o)); // R10
endmodule

// File: tb/pwr_seq_ctrl_bench.sv
module pwr_seq_ctrl_bench;
  localparam int CW  = 12;
  localparam int TGT = 1000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [CW-1:0] vin_code_i = '0, vbias_code_i = '0, en_code_i = '0, fb_code_i = '0;
  logic          restart_i = 1'b0;
  logic [CW-1:0] ref_o;
  logic          sw_en_o, deep_sd_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  pwr_seq_ctrl #(.RAMP_NS(8000)) u_pwr_seq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .vin_code_i(vin_code_i), .vbias_code_i(vbias_code_i),
    .en_code_i(en_code_i), .fb_code_i(fb_code_i), .restart_i(restart_i),
    .ref_o(ref_o), .sw_en_o(sw_en_o), .deep_sd_o(deep_sd_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ramp from below fb until switching; R6 edge at fb+2
  task automatic run_to_reg(input string req);
    int n = 0;
    while (!sw_en_o && n < 3000) begin
      tick(1);
      n++;
    end
    chk(sw_en_o, req, int'(sw_en_o), 1);
    chk(int'(ref_o) == int'(fb_code_i) + 2, req, int'(ref_o), int'(fb_code_i) + 2);
  endtask

  task automatic t_reset();
    tick(3);
    chk(deep_sd_o == 1'b1, "R10 deep", int'(deep_sd_o), 1);
    chk(sw_en_o == 1'b0, "R10 sw", int'(sw_en_o), 0);
    chk(ref_o == '0, "R10 ref", int'(ref_o), 0);
  endtask

  task automatic t_startup();
    int cyc = 0, c1 = -1, c2 = -1, prev = 0, bad_lin = 0, sw_early = 0;
    bit seen = 0;
    vin_code_i = 3000; vbias_code_i = 3000; en_code_i = 1200; fb_code_i = 300;
    rst_ni = 1'b1;
    tick(3);
    chk(int'(ref_o) == 1, "R1 first step", int'(ref_o), 1);
    prev = int'(ref_o); c1 = 0;
    while (cyc < 1500) begin
      tick(1);
      cyc++;
      if (prev < TGT && int'(ref_o) != prev + 1) bad_lin++;
      if (c2 < 0 && int'(ref_o) == TGT) c2 = cyc;
      if (sw_en_o && !seen) begin
        seen = 1;
        chk(int'(ref_o) == 302, "R6 sw edge", int'(ref_o), 302);
      end
      if (!sw_en_o && int'(ref_o) > 302) sw_early++;
      if (!sw_en_o && seen) sw_early++;
      prev = int'(ref_o);
    end
    chk(bad_lin == 0, "R5 linear", bad_lin, 0);
    chk(c2 - c1 == 999, "R5 ramp length", c2 - c1, 999);
    chk(int'(ref_o) == TGT, "R5 saturate", int'(ref_o), TGT);
    chk(sw_early == 0, "R6 sw stays", sw_early, 0);
  endtask

  task automatic t_rail_hyst();
    vin_code_i = 2700; tick(5);
    chk(sw_en_o == 1'b1, "R2 in band", int'(sw_en_o), 1);
    vin_code_i = 2600; tick(5);
    chk(sw_en_o == 1'b1, "R2 at off", int'(sw_en_o), 1);
    vin_code_i = 2599; tick(1);
    chk(sw_en_o == 1'b0, "R9 sw drop", int'(sw_en_o), 0);
    tick(1);
    chk(ref_o == '0, "R9 ref zero", int'(ref_o), 0);
    vin_code_i = 2800; tick(40);
    chk(ref_o == '0, "R2 no requal in band", int'(ref_o), 0);
    vin_code_i = 2901; tick(3);
    chk(int'(ref_o) == 1, "R1 requal", int'(ref_o), 1);
    run_to_reg("R6 rail restart");
  endtask

  task automatic t_bias();
    vbias_code_i = 2500; tick(2);
    chk(ref_o == '0 && !sw_en_o, "R9 bias loss", int'(ref_o), 0);
    vbias_code_i = 2900; tick(40);
    chk(ref_o == '0, "R1 at on not enough", int'(ref_o), 0);
    vbias_code_i = 2901; tick(3);
    chk(int'(ref_o) == 1, "R1 bias qual", int'(ref_o), 1);
    run_to_reg("R6 bias restart");
  endtask

  task automatic t_en_hyst();
    en_code_i = 1070; tick(5);
    chk(sw_en_o == 1'b1, "R3 en at off", int'(sw_en_o), 1);
    en_code_i = 1069; tick(1);
    chk(sw_en_o == 1'b0, "R3 en drop", int'(sw_en_o), 0);
    chk(deep_sd_o == 1'b0, "R3 not deep", int'(deep_sd_o), 0);
    tick(1);
    chk(ref_o == '0, "R9 en ref zero", int'(ref_o), 0);
    en_code_i = 1170; tick(40);
    chk(ref_o == '0, "R3 en at on", int'(ref_o), 0);
    en_code_i = 1171; tick(3);
    chk(int'(ref_o) == 1, "R3 en qual", int'(ref_o), 1);
    run_to_reg("R6 en restart");
  endtask

  task automatic t_restart();
    tick(20);
    chk(sw_en_o == 1'b1, "R8 pre", int'(sw_en_o), 1);
    restart_i = 1'b1; tick(1); restart_i = 1'b0;
    chk(ref_o == '0, "R8 ref zero", int'(ref_o), 0);
    chk(sw_en_o == 1'b0, "R8 sw low", int'(sw_en_o), 0);
    tick(1);
    chk(int'(ref_o) == 1, "R8 re-ramp", int'(ref_o), 1);
    run_to_reg("R8 regulate again");
  endtask

  task automatic t_deep();
    en_code_i = 700; vin_code_i = 2700; tick(1);
    chk(deep_sd_o == 1'b1, "R4 deep set", int'(deep_sd_o), 1);
    chk(sw_en_o == 1'b0, "R4 sw low", int'(sw_en_o), 0);
    chk(ref_o == '0, "R4 ref zero", int'(ref_o), 0);
    tick(5);
    en_code_i = 1200; tick(1);
    chk(deep_sd_o == 1'b0, "R4 deep exit", int'(deep_sd_o), 0);
    tick(40);
    chk(ref_o == '0, "R4 rails cleared", int'(ref_o), 0);
    vin_code_i = 3000; tick(3);
    chk(int'(ref_o) == 1, "R4 requal", int'(ref_o), 1);
    run_to_reg("R6 after deep");
  endtask

  task automatic t_prebias();
    int sw_seen = 0;
    en_code_i = 1000; tick(2);
    fb_code_i = TGT; en_code_i = 1200;
    for (int i = 0; i < 1500; i++) begin
      tick(1);
      if (sw_en_o) sw_seen++;
    end
    chk(sw_seen == 0, "R7 no switching", sw_seen, 0);
    chk(int'(ref_o) == TGT, "R7 ref at target", int'(ref_o), TGT);
    fb_code_i = 300; tick(2);
    chk(sw_en_o == 1'b1, "R6 late start", int'(sw_en_o), 1);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_rail_hyst();
    t_bias();
    t_en_hyst();
    t_restart();
    t_deep();
    t_prebias();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule